// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one burst request into the sequence of byte addresses that its beats occupy. A request gives a start address, a length field (beat count minus one), a size field (log2 of the bytes per beat) and a burst kind. The block accepts it with a load strobe. It then presents the address of the current beat and moves to the next beat each time the next-beat strobe is seen.

Three addressing kinds are supported. In a fixed burst every beat uses the start address. In an incrementing burst the address climbs by the beat size. In a wrapping burst the address climbs inside an aligned block and falls back to the block's lowest byte when it passes the block's end. Requests that the bus rules forbid are refused at load time: a reserved kind, an oversize beat, a bad wrap or fixed length, or an incrementing burst that crosses a 4 KB page. A refused request raises an error flag and starts nothing.

The block is meant to sit beside a burst master or slave channel and feed its address path. Byte-lane strobes, data and handshakes are left to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, busy_o, last_o and err_o are all 0.
- R2: With kind_i = 2'b00 (fixed), beat_addr_o holds the start address on every beat of the burst.
- R3: With kind_i = 2'b01 (incrementing), the first beat is at the start address. Every later beat is at the start address rounded down to a multiple of 2^size_i, plus the beat index times 2^size_i, so later beats are aligned even when the start is not.
- R4: With kind_i = 2'b10 (wrapping), the block is 2^size_i × (len_i+1) bytes, aligned to its own size, and contains the start address. Beats step by 2^size_i inside that block and return to its lowest address on passing its end.
- R5: A legal load sets busy_o on the next clock and the burst then has len_i+1 beats. last_o is 1 exactly while the final beat is presented, and busy_o drops on the clock that accepts that beat with next_i.
- R6: A wrapping request with len_i other than 1, 3, 7 or 15 is refused: err_o becomes 1 and busy_o stays 0.
- R7: A fixed request with len_i above 15 is refused.
- R8: An incrementing request is refused when the start page offset, rounded down to the beat size, plus (len_i+1)×2^size_i exceeds 4096. Ending exactly at 4096 is legal.
- R9: A request with 2^size_i larger than the data bus width in bytes (parameter BUS_BYTES, default 4) is refused.
- R10: A request with kind_i = 2'b11 is refused.
- R11: A load strobe while busy_o is 1 is ignored: the running burst continues with unchanged addresses and err_o unchanged.
- R12: next_i while idle has no effect. err_o changes only on a load taken while idle: it becomes 1 for a refused request and 0 for a legal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Take a new request (idle only) |
| start_addr_i | input | ADDR_W | Start byte address of the request |
| len_i | input | 8 | Beat count minus one |
| size_i | input | 3 | Log2 of bytes per beat |
| kind_i | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| next_i | input | 1 | Current beat accepted, advance |
| beat_addr_o | output | ADDR_W | Byte address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |
| err_o | output | 1 | Last taken request was refused |

## Verification
Fixed bursts show whether the address is held at the start value. Incrementing bursts are tried with an unaligned start, with byte-wide beats and with one that ends exactly on a 4 KB page edge. These separate correct realignment after the first beat from a plain add, and an off-by-one page check from a correct one. Wrapping bursts are tried at two block sizes with a start in mid-block, which shows whether the fall-back lands on the block base. Each refusal rule is applied alone and then followed by a legal load. This shows that exactly that rule raises the flag and that the flag clears. Loads during a burst and strobes while idle confirm that they are ignored.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int PAGE_BITS     = 12;
    localparam int SPAN_W        = 17;
    localparam int SHORT_MAX_LEN = 15;

    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10,
        BK_RSVD  = 2'b11
    } burst_kind_e;

    typedef struct packed {
        burst_kind_e kind;
        logic [2:0]  size;
        logic [7:0]  len;
    } burst_ctx_t;

    function automatic logic wrap_len_ok(input logic [7:0] len);
        return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    endfunction

    function automatic logic [SPAN_W-1:0] span_bytes(input logic [7:0] len,
                                                     input logic [2:0] size);
        return (SPAN_W'(len) + SPAN_W'(1)) << size;
    endfunction

endpackage

// File: rtl/bag_legal.sv
module bag_legal
    import bag_pkg::*;
#(
    parameter int MAX_SIZE = 2
) (
    input  logic [PAGE_BITS-1:0] page_off_i,
    input  burst_ctx_t           ctx_i,
    output logic                 bad_o
);

    logic [SPAN_W-1:0] beat_b;
    logic [SPAN_W-1:0] off_al;
    logic [SPAN_W-1:0] end_b;
    logic              kind_bad;

    always_comb begin
        beat_b = SPAN_W'(1) << ctx_i.size;
        off_al = SPAN_W'(page_off_i) & ~(beat_b - SPAN_W'(1));
        end_b  = off_al + span_bytes(ctx_i.len, ctx_i.size);
        case (ctx_i.kind)
            BK_FIXED: kind_bad = ctx_i.len > 8'(SHORT_MAX_LEN);
            BK_INCR:  kind_bad = end_b > (SPAN_W'(1) << PAGE_BITS);
            BK_WRAP:  kind_bad = !wrap_len_ok(ctx_i.len);
            default:  kind_bad = 1'b1;
        endcase
        bad_o = kind_bad || (int'(ctx_i.size) > MAX_SIZE);
    end

endmodule

// File: rtl/bag_next.sv
module bag_next
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  burst_ctx_t        ctx_i,
    output logic [ADDR_W-1:0] next_o
);

    logic [ADDR_W-1:0] beat_b;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] wmask;

    always_comb begin
        beat_b  = ADDR_W'(1) << ctx_i.size;
        aligned = addr_i & ~(beat_b - ADDR_W'(1));
        stepped = aligned + beat_b;
        wmask   = ((ADDR_W'(ctx_i.len) + ADDR_W'(1)) << ctx_i.size) - ADDR_W'(1);
        case (ctx_i.kind)
            BK_INCR: next_o = stepped;
            BK_WRAP: next_o = (aligned & ~wmask) | (stepped & wmask);
            default: next_o = addr_i;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [7:0]        len_i,
    input  logic [2:0]        size_i,
    input  logic [1:0]        kind_i,
    input  logic              next_i,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              err_o
);

    localparam int MAX_SIZE = $clog2(BUS_BYTES);

    burst_ctx_t        ctx_in;
    burst_ctx_t        ctx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [7:0]        left_q;
    logic              busy_q;
    logic              err_q;
    logic              bad;
    logic              accept;
    logic              step;

    assign ctx_in = '{kind: burst_kind_e'(kind_i), size: size_i, len: len_i};
    assign accept = load_i && !busy_q;
    assign step   = next_i && busy_q;

    bag_legal #(.MAX_SIZE(MAX_SIZE)) u_legal (
        .page_off_i (start_addr_i[PAGE_BITS-1:0]),
        .ctx_i      (ctx_in),
        .bad_o      (bad)
    );

    bag_next #(.ADDR_W(ADDR_W)) u_next (
        .addr_i (addr_q),
        .ctx_i  (ctx_q),
        .next_o (addr_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            addr_q <= '0;
            left_q <= '0;
            ctx_q  <= '{kind: BK_FIXED, size: '0, len: '0};
        end else if (accept) begin
            err_q <= bad;
            if (!bad) begin
                busy_q <= 1'b1;
                addr_q <= start_addr_i;
                left_q <= len_i;
                ctx_q  <= ctx_in;
            end
        end else if (step) begin
            if (left_q == 8'd0) begin
                busy_q <= 1'b0;
            end else begin
                addr_q <= addr_nxt;
                left_q <= left_q - 8'd1;
            end
        end
    end

    assign beat_addr_o = addr_q;
    assign last_o      = busy_q && (left_q == 8'd0);
    assign busy_o      = busy_q;
    assign err_o       = err_q;

endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [7:0]        len_i,
    input logic [2:0]        size_i,
    input logic [1:0]        kind_i,
    input logic              next_i,
    input logic [ADDR_W-1:0] beat_addr_o,
    input logic              last_o,
    input logic              busy_o,
    input logic              err_o
);

    logic [1:0]        kind_q;
    logic [2:0]        size_q;
    logic [7:0]        len_q;
    logic [ADDR_W-1:0] bmask;
    logic [ADDR_W-1:0] wmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= '0;
            size_q <= '0;
            len_q  <= '0;
        end else if (load_i && !busy_o) begin
            kind_q <= kind_i;
            size_q <= size_i;
            len_q  <= len_i;
        end
    end

    assign bmask = (ADDR_W'(1) << size_q) - ADDR_W'(1);
    assign wmask = ((ADDR_W'(len_q) + ADDR_W'(1)) << size_q) - ADDR_W'(1);

    assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
        last_o |-> busy_o);

    assert_final_accept_R5: assert property (@(posedge clk) disable iff (rst)
        busy_o && next_i && last_o |=> !busy_o);

    assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o && next_i && !last_o && kind_q == 2'b00 |=> $stable(beat_addr_o));

    assert_incr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        busy_o && next_i && !last_o && kind_q == 2'b01 |=> (beat_addr_o & bmask) == '0);

    assert_wrap_block_R4: assert property (@(posedge clk) disable iff (rst)
        busy_o && next_i && !last_o && kind_q == 2'b10 |=>
            ((beat_addr_o ^ $past(beat_addr_o)) & ~wmask) == '0);

    assert_reserved_err_R10: assert property (@(posedge clk) disable iff (rst)
        load_i && !busy_o && kind_i == 2'b11 |=> err_o && !busy_o);

    assert_busy_load_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        busy_o && load_i && !next_i |=> busy_o && $stable(beat_addr_o) && $stable(err_o));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy_o && !load_i |=> !busy_o && $stable(err_o));

endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [7:0]  len_i = '0;
    logic [2:0]  size_i = '0;
    logic [1:0]  kind_i = '0;
    logic        next_i = 1'b0;
    logic [31:0] beat_addr_o;
    logic        last_o;
    logic        busy_o;
    logic        err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    burst_addr_gen i_burst_addr_gen (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input int l,
                                             input int s, input int k, input int i);
        logic [31:0] b, blk, base, al;
        b  = 32'(1) << s;
        al = a & ~(b - 1);
        if (i == 0 || k == 0) return a;
        if (k == 1) return al + 32'(i) * b;
        blk  = b * 32'(l + 1);
        base = a & ~(blk - 1);
        return base + ((al - base + 32'(i) * b) % blk);
    endfunction

    task automatic do_load(input logic [31:0] a, input int l, input int s, input int k);
        @(negedge clk);
        start_addr_i = a; len_i = 8'(l); size_i = 3'(s); kind_i = 2'(k); load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic run_burst(input string tag, input logic [31:0] a, input int l,
                             input int s, input int k);
        do_load(a, l, s, k);
        chk({tag, " R5 busy after load"}, 32'(busy_o), 1);
        chk({tag, " R12 err cleared by legal load"}, 32'(err_o), 0);
        for (int i = 0; i <= l; i++) begin
            chk($sformatf("%s beat %0d addr", tag, i), beat_addr_o, exp_addr(a, l, s, k, i));
            chk($sformatf("%s R5 last at beat %0d", tag, i), 32'(last_o), 32'(i == l));
            next_i = 1'b1;
            @(negedge clk);
            next_i = 1'b0;
        end
        chk({tag, " R5 idle after final beat"}, 32'(busy_o), 0);
    endtask

    task automatic refuse(input string tag, input logic [31:0] a, input int l,
                          input int s, input int k);
        do_load(a, l, s, k);
        chk({tag, " refused: err"}, 32'(err_o), 1);
        chk({tag, " refused: not busy"}, 32'(busy_o), 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 last", 32'(last_o), 0);
        chk("R1 err", 32'(err_o), 0);
    endtask

    task automatic t_addressing;
        run_burst("R2 fixed", 32'h0000_0100, 3, 2, 0);
        run_burst("R3 incr unaligned", 32'h0000_1003, 4, 2, 1);
        run_burst("R3 incr bytes", 32'h0000_2000, 255, 0, 1);
        run_burst("R8 incr ends on page edge", 32'h0000_0FF0, 3, 2, 1);
        run_burst("R4 wrap 4x4", 32'h0000_0034, 3, 2, 2);
        run_burst("R4 wrap 16x1", 32'h0000_0047, 15, 0, 2);
    endtask

    task automatic t_refusals;
        refuse("R6 wrap len 3 beats", 32'h40, 2, 2, 2);
        run_burst("R12 legal after refusal", 32'h80, 1, 1, 1);
        refuse("R7 fixed 17 beats", 32'h40, 16, 2, 0);
        refuse("R8 incr crosses page", 32'hFF8, 2, 2, 1);
        refuse("R9 oversize beat", 32'h40, 0, 3, 1);
        refuse("R10 reserved kind", 32'h40, 0, 0, 3);
    endtask

    task automatic t_busy_load;
        do_load(32'h0000_0200, 3, 2, 1);
        next_i = 1'b1;
        @(negedge clk);
        next_i = 1'b0;
        do_load(32'h0000_0900, 0, 3, 3);
        chk("R11 busy kept", 32'(busy_o), 1);
        chk("R11 addr kept", beat_addr_o, 32'h204);
        chk("R11 err kept", 32'(err_o), 0);
        for (int i = 1; i <= 3; i++) begin
            chk($sformatf("R11 continued beat %0d", i), beat_addr_o, 32'h200 + 32'(i) * 4);
            next_i = 1'b1;
            @(negedge clk);
            next_i = 1'b0;
        end
        chk("R11 burst ends", 32'(busy_o), 0);
    endtask

    task automatic t_idle_next;
        refuse("R12 set err", 32'h0, 0, 0, 3);
        next_i = 1'b1;
        repeat (3) @(negedge clk);
        next_i = 1'b0;
        chk("R12 idle next busy", 32'(busy_o), 0);
        chk("R12 idle next err", 32'(err_o), 1);
        chk("R12 idle next last", 32'(last_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addressing();
        t_refusals();
        t_busy_load();
        t_idle_next();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule